// File: doc/BRIEF.md
# Configurable External Memory Bus Controller

This block turns single requests from an internal request/acknowledge port into bus cycles on external memory pins. A request carries a read/write flag, an address, write data and two byte enables. The controller drives an address-latch pulse, an active-low read strobe and two active-low write strobes. It also drives two bus-wide tristatable ports. The first port carries address and data, or data only. The second port carries a stable address. Each port has its own output-enable vector.

Three configuration inputs set the layout, and they are captured when a request is accepted. The first picks multiplexed or demultiplexed pin use. The second picks a full-width or half-width data path. The third picks the write-strobe style: one common strobe, or separate low-byte and high-byte strobes. Every bus cycle runs through four states: an address phase of one clock, a command phase of `CMD_CYCLES` clocks, and an end clock in which the acknowledge is returned. On a half-width path each request moves one byte, which travels on the low half of the data lines.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, and in every idle clock, `ale` is 0, `rd_n`, `wr_n` and `wrh_n` are 1, `ack` is 0, and every bit of `p0_oe` and `p1_oe` is 0. `rdata` resets to 0.
- R2: A request seen in the idle state starts the following sequence: one address clock, then exactly `CMD_CYCLES` command clocks, then one end clock. `ack` is 1 in the end clock only, and the controller then returns to idle.
- R3: `ale` is 1 during the address clock when multiplexed mode is selected (`cfg_mux`=1). It is never 1 in demultiplexed mode.
- R4: In multiplexed mode the full address is driven on `p0` with all enables set during the address clock. At half width, the upper half of `p0` keeps driving the upper address bits through the command and end clocks.
- R5: In multiplexed mode, during the command clocks of a write, the write data are driven on the data lines of `p0`: bits [15:0] at full width, and `req_wdata[7:0]` on bits [7:0] at half width. During a read, those same lines are released (enable 0).
- R6: In demultiplexed mode `p1` drives the full address with all enables set during the address, command and end clocks. `p0` drives write data only during the command clocks. At half width, `p0[15:8]` is never enabled. In multiplexed mode `p1` is never enabled.
- R7: `rd_n` is 0 in every command clock of a read and 1 at all other times.
- R8: With `cfg_wrl`=0, `wr_n` is 0 in every command clock of every write, whatever the byte enables are, and `wrh_n` stays 1.
- R9: With `cfg_wrl`=1, `wr_n` is 0 in the command clocks of a write only when the data path is half width or `req_be[0]`=1. `wrh_n` is 0 in those clocks only when the path is full width and `req_be[1]`=1.
- R10: Read data are sampled from `p0_in` on the last command clock. The value is `p0_in[15:0]` at full width and {8'h00, `p0_in[7:0]`} at half width. It appears on `rdata` from the end clock onward and holds until the next read samples.
- R11: The configuration inputs and request fields are captured when the request is accepted. Changing them during the bus cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mux | input | 1 | 1 = multiplexed address/data, 0 = demultiplexed |
| cfg_wide | input | 1 | 1 = full-width data path, 0 = half width |
| cfg_wrl | input | 1 | 1 = split low/high byte write strobes, 0 = one common write strobe |
| req | input | 1 | Request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | BUS_W | Request address |
| req_wdata | input | BUS_W | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| ack | output | 1 | One-clock acknowledge in the end clock |
| rdata | output | BUS_W | Captured read data |
| p0_in | input | BUS_W | Pin levels of the address/data port |
| p0_out | output | BUS_W | Drive values of the address/data port |
| p0_oe | output | BUS_W | Per-bit enables of the address/data port |
| p1_out | output | BUS_W | Drive values of the address port |
| p1_oe | output | BUS_W | Per-bit enables of the address port |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe (common or low byte), active low |
| wrh_n | output | 1 | High-byte write strobe, active low |

## Verification
The bench runs all four pin layouts under both write-strobe styles. It uses full, low-only and high-only byte enables, and it compares every output pin against a behavioural model on every clock. The corner cases are these:
- A half-width multiplexed cycle must hold the upper address bits through the command phase. A design that dropped them would show released upper pins.
- A read must release the shared lines. A design that kept driving would show enables set during a read command.
- The low-byte style with a high-only byte enable must leave `wr_n` high. A wrong decode would pulse the low strobe for a high-byte write.
- Half-width reads must zero the upper bits of `rdata`.

One cycle switches the configuration inputs and the address while the cycle is running, to expose a design that decodes the live inputs instead of the captured ones.

// File: rtl/ebc_pkg.sv
// Package: shared types of the external bus controller.
// Assumes: one bus cycle in flight at a time.
package ebc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_CMD  = 2'd2,
        ST_END  = 2'd3
    } bus_state_t;

    typedef struct packed {
        logic mux;   // 1 = multiplexed address/data
        logic wide;  // 1 = full-width data path
        logic wrl;   // 1 = split low/high byte write strobes
    } bus_cfg_t;
endpackage

// File: rtl/ebc_seq.sv
// Module: bus cycle sequencer. Steps IDLE -> ADDR -> CMD (CMD_CYCLES clocks)
// -> END -> IDLE. A cycle is accepted only in IDLE.
// Assumes: CMD_CYCLES >= 1; the request is held high until acknowledged.
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int CMD_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    output bus_state_t st,
    output logic       accept,
    output logic       cmd_last
);
    localparam int CW = $clog2(CMD_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Accept a new request only while idle.
    assign accept   = (st == ST_IDLE) && req;
    // Flag the final clock of the command phase.
    assign cmd_last = (st == ST_CMD) && (cnt == CW'(CMD_CYCLES - 1));

    // State register and command-phase clock counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req) st <= ST_ADDR;
                ST_ADDR: begin
                    st  <= ST_CMD;
                    cnt <= '0;
                end
                ST_CMD: begin
                    if (cmd_last) st <= ST_END;
                    else          cnt <= cnt + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Independent count of command clocks, used only by the check below.
    logic [CW:0] chk_len;
    always_ff @(posedge clk) begin
        if (!rst_n)             chk_len <= '0;
        else if (st == ST_CMD)  chk_len <= chk_len + 1'b1;
        else                    chk_len <= '0;
    end

    // R2: the command phase lasts exactly CMD_CYCLES clocks.
    assert_cmd_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_END) |-> (chk_len == (CW+1)'(CMD_CYCLES)));

    // R2: the end clock is always followed by idle.
    assert_end_to_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_END) |=> (st == ST_IDLE));
endmodule

// File: rtl/ebc_pinmux.sv
// Module: pin mapper. Decides from the state, the captured configuration and
// the captured request what each half of both ports drives.
// Assumes: BUS_W is even; inputs come from registers captured at acceptance.
module ebc_pinmux
    import ebc_pkg::*;
#(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_state_t       st,
    input  bus_cfg_t         cfg,
    input  logic             we,
    input  logic [BUS_W-1:0] addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] p0_out,
    output logic [BUS_W-1:0] p0_oe,
    output logic [BUS_W-1:0] p1_out,
    output logic [BUS_W-1:0] p1_oe,
    output logic             ale
);
    localparam int HALF = BUS_W / 2;

    logic ph_addr, ph_cmd, ph_busy, wr_cmd;
    assign ph_addr = (st == ST_ADDR);
    assign ph_cmd  = (st == ST_CMD);
    assign ph_busy = (st != ST_IDLE);
    assign wr_cmd  = ph_cmd && we;

    // Address latch pulse only in the multiplexed address phase.
    assign ale = cfg.mux && ph_addr;

    // Low half of the first port: address (multiplexed) then write data.
    always_comb begin
        p0_out[HALF-1:0] = '0;
        p0_oe[HALF-1:0]  = '0;
        if (cfg.mux && ph_addr) begin
            p0_out[HALF-1:0] = addr[HALF-1:0];
            p0_oe[HALF-1:0]  = '1;
        end else if (wr_cmd) begin
            p0_out[HALF-1:0] = wdata[HALF-1:0];
            p0_oe[HALF-1:0]  = '1;
        end
    end

    // High half of the first port: depends on both mux and width.
    always_comb begin
        p0_out[BUS_W-1:HALF] = '0;
        p0_oe[BUS_W-1:HALF]  = '0;
        if (cfg.mux && !cfg.wide) begin
            if (ph_busy) begin
                p0_out[BUS_W-1:HALF] = addr[BUS_W-1:HALF];
                p0_oe[BUS_W-1:HALF]  = '1;
            end
        end else if (cfg.mux && cfg.wide) begin
            if (ph_addr) begin
                p0_out[BUS_W-1:HALF] = addr[BUS_W-1:HALF];
                p0_oe[BUS_W-1:HALF]  = '1;
            end else if (wr_cmd) begin
                p0_out[BUS_W-1:HALF] = wdata[BUS_W-1:HALF];
                p0_oe[BUS_W-1:HALF]  = '1;
            end
        end else if (cfg.wide && wr_cmd) begin
            p0_out[BUS_W-1:HALF] = wdata[BUS_W-1:HALF];
            p0_oe[BUS_W-1:HALF]  = '1;
        end
    end

    // Second port: full address for the whole demultiplexed cycle.
    always_comb begin
        if (!cfg.mux && ph_busy) begin
            p1_out = addr;
            p1_oe  = '1;
        end else begin
            p1_out = '0;
            p1_oe  = '0;
        end
    end

    // R5: no drive on the low data lines while a read command is in progress.
    assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_cmd && !we) |-> (p0_oe[HALF-1:0] == '0));

    // R3: the address latch pulse is never longer than one clock.
    assert_ale_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R6: the two ports never both carry the address at once.
    assert_port_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_oe != '0) |-> !ale);
endmodule

// File: rtl/ebc_strobe.sv
// Module: strobe decoder. Produces the active-low read strobe and the two
// write strobes from the state, the captured direction, the byte enables and
// the write-strobe style.
// Assumes: inputs are stable for the whole bus cycle.
module ebc_strobe
    import ebc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_state_t st,
    input  bus_cfg_t   cfg,
    input  logic       we,
    input  logic [1:0] be,
    output logic       rd_n,
    output logic       wr_n,
    output logic       wrh_n
);
    logic ph_cmd, lo_hit, hi_hit;
    assign ph_cmd = (st == ST_CMD);

    // Byte-style selections: low strobe covers half width or the low lane.
    assign lo_hit = !cfg.wrl || !cfg.wide || be[0];
    assign hi_hit = cfg.wrl && cfg.wide && be[1];

    // Strobe outputs, all active low and only in the command phase.
    always_comb begin
        rd_n  = !(ph_cmd && !we);
        wr_n  = !(ph_cmd && we && lo_hit);
        wrh_n = !(ph_cmd && we && hi_hit);
    end

    // R7: a read strobe never overlaps a write strobe.
    assert_rd_wr_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> (wr_n && wrh_n));

    // R8: the common-strobe style never uses the high-byte strobe.
    assert_wrh_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.wrl |-> wrh_n);

    // R9: the high-byte strobe is only used at full width.
    assert_wrh_wide_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wrh_n |-> cfg.wide);
endmodule

// File: rtl/ebc_rdcap.sv
// Module: read data capture. Samples the address/data port on the last
// command clock of a read and holds it.
// Assumes: cap_en is a single-clock pulse.
module ebc_rdcap #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             wide,
    input  logic [BUS_W-1:0] pin_in,
    output logic [BUS_W-1:0] rdata
);
    localparam int HALF = BUS_W / 2;

    // Capture register; half width fills the upper lane with zeros.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (cap_en)
            rdata <= wide ? pin_in : {{HALF{1'b0}}, pin_in[HALF-1:0]};
    end

    // R10: captured data holds when no capture is requested.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(rdata));
endmodule

// File: rtl/ext_bus_ctrl.sv
// Module: external bus controller top. Captures a request and the
// configuration on acceptance, sequences the bus cycle, maps the pins,
// decodes the strobes and captures read data.
// Assumes: the requester holds req and its fields until ack.
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int BUS_W      = 16,
    parameter int CMD_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mux,
    input  logic             cfg_wide,
    input  logic             cfg_wrl,
    input  logic             req,
    input  logic             req_we,
    input  logic [BUS_W-1:0] req_addr,
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [1:0]       req_be,
    output logic             ack,
    output logic [BUS_W-1:0] rdata,
    input  logic [BUS_W-1:0] p0_in,
    output logic [BUS_W-1:0] p0_out,
    output logic [BUS_W-1:0] p0_oe,
    output logic [BUS_W-1:0] p1_out,
    output logic [BUS_W-1:0] p1_oe,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic             wrh_n
);
    bus_state_t       st;
    logic             accept, cmd_last;
    bus_cfg_t         cfg_q;
    logic             we_q;
    logic [1:0]       be_q;
    logic [BUS_W-1:0] addr_q, wdata_q;

    // Capture configuration and request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            we_q    <= 1'b0;
            be_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            cfg_q   <= '{mux: cfg_mux, wide: cfg_wide, wrl: cfg_wrl};
            we_q    <= req_we;
            be_q    <= req_be;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Acknowledge in the end clock.
    assign ack = (st == ST_END);

    ebc_seq #(.CMD_CYCLES(CMD_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .st       (st),
        .accept   (accept),
        .cmd_last (cmd_last)
    );

    ebc_pinmux #(.BUS_W(BUS_W)) u_pinmux (
        .clk    (clk),
        .rst_n  (rst_n),
        .st     (st),
        .cfg    (cfg_q),
        .we     (we_q),
        .addr   (addr_q),
        .wdata  (wdata_q),
        .p0_out (p0_out),
        .p0_oe  (p0_oe),
        .p1_out (p1_out),
        .p1_oe  (p1_oe),
        .ale    (ale)
    );

    ebc_strobe u_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .st    (st),
        .cfg   (cfg_q),
        .we    (we_q),
        .be    (be_q),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .wrh_n (wrh_n)
    );

    ebc_rdcap #(.BUS_W(BUS_W)) u_rdcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cmd_last && !we_q),
        .wide   (cfg_q.wide),
        .pin_in (p0_in),
        .rdata  (rdata)
    );

    // R2: acknowledge is a single-clock pulse.
    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R1: nothing is driven while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (p0_oe == '0 && p1_oe == '0 && rd_n && wr_n && wrh_n));
endmodule

// File: tb/ext_bus_ctrl_tb.sv
module ext_bus_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int N = 2;
    localparam int H = W / 2;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_mux = 0, cfg_wide = 0, cfg_wrl = 0;
    logic req = 0, req_we = 0;
    logic [W-1:0] req_addr = '0, req_wdata = '0, p0_in = '0;
    logic [1:0] req_be = '0;
    logic ack, ale, rd_n, wr_n, wrh_n;
    logic [W-1:0] rdata, p0_out, p0_oe, p1_out, p1_oe;

    integer checks = 0, errors = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_ctrl #(.BUS_W(W), .CMD_CYCLES(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mux(cfg_mux), .cfg_wide(cfg_wide),
        .cfg_wrl(cfg_wrl), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .ack(ack), .rdata(rdata),
        .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe), .p1_out(p1_out),
        .p1_oe(p1_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .wrh_n(wrh_n)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural model: phase 0 idle, 1 address, 2..N+1 command, N+2 end.
    integer ph = 0;
    logic m_mux = 0, m_wide = 0, m_wrl = 0, m_we = 0;
    logic [1:0] m_be = 0;
    logic [W-1:0] m_addr = 0, m_wdata = 0, m_rdata = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0;
            m_rdata = 0;
        end else if (ph == 0) begin
            if (req) begin
                m_mux = cfg_mux; m_wide = cfg_wide; m_wrl = cfg_wrl;
                m_we = req_we; m_be = req_be; m_addr = req_addr; m_wdata = req_wdata;
                ph = 1;
            end
        end else if (ph == N + 1) begin
            if (!m_we) m_rdata = m_wide ? p0_in : {8'h00, p0_in[7:0]};
            ph = N + 2;
        end else if (ph == N + 2) begin
            ph = 0;
        end else begin
            ph = ph + 1;
        end
    end

    // Compare every output against the model away from the active edge.
    logic compare_on = 0;
    always @(negedge clk) begin
        if (compare_on) begin
            logic is_addr, is_cmd, is_end, busy;
            logic e_ale, e_rd, e_wr, e_wrh, e_ack;
            logic [W-1:0] e0o, e0e, e1o, e1e;
            string t0, tw;
            busy = (ph != 0);
            is_addr = (ph == 1);
            is_cmd = (ph >= 2) && (ph <= N + 1);
            is_end = (ph == N + 2);
            e_ale = busy && m_mux && is_addr;
            e_rd  = !(is_cmd && !m_we);
            e_wr  = !(is_cmd && m_we && (!m_wrl || !m_wide || m_be[0]));
            e_wrh = !(is_cmd && m_we && m_wrl && m_wide && m_be[1]);
            e_ack = is_end;
            e0o = 0; e0e = 0; e1o = 0; e1e = 0;
            if (busy) begin
                if (m_mux) begin
                    if (is_addr) begin e0o = m_addr; e0e = '1; end
                    else if (is_cmd && m_we) begin
                        if (m_wide) begin e0o = m_wdata; e0e = '1; end
                        else begin e0o = {m_addr[15:8], m_wdata[7:0]}; e0e = '1; end
                    end else if (!m_wide) begin
                        e0o = {m_addr[15:8], 8'h00}; e0e = 16'hFF00;
                    end
                end else begin
                    e1o = m_addr; e1e = '1;
                    if (is_cmd && m_we) begin
                        if (m_wide) begin e0o = m_wdata; e0e = '1; end
                        else begin e0o = {8'h00, m_wdata[7:0]}; e0e = 16'h00FF; end
                    end
                end
            end
            t0 = !busy ? "R1" : (!m_mux ? "R6" : (is_addr ? "R4" : "R5"));
            tw = !busy ? "R1" : (m_wrl ? "R9" : "R8");
            chk(busy ? "R3" : "R1", "ale", ale, e_ale);
            chk(busy ? "R7" : "R1", "rd_n", rd_n, e_rd);
            chk(tw, "wr_n", wr_n, e_wr);
            chk(tw, "wrh_n", wrh_n, e_wrh);
            chk(busy ? "R2" : "R1", "ack", ack, e_ack);
            chk(t0, "p0_oe", p0_oe, e0e);
            chk(t0, "p0_out", p0_out & p0_oe, e0o);
            chk(busy ? "R6" : "R1", "p1_oe", p1_oe, e1e);
            chk(busy ? "R6" : "R1", "p1_out", p1_out & p1_oe, e1o);
            chk("R10", "rdata", rdata, m_rdata);
        end
    end

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic bus_op(input logic we, input logic [W-1:0] a,
                          input logic [W-1:0] d, input logic [1:0] be);
        @(posedge clk); #1;
        req = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        p0_in = ~a ^ 16'h5A3C;
        do @(negedge clk); while (!ack);
        @(posedge clk); #1;
        req = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset ale", ale, 0);
        chk("R1", "reset strobes", {rd_n, wr_n, wrh_n}, 3'b111);
        chk("R1", "reset oe", {p0_oe, p1_oe}, 0);
        chk("R1", "reset rdata", rdata, 0);
        compare_on = 1;

        for (int m = 0; m < 4; m++) begin
            for (int s = 0; s < 2; s++) begin
                cfg_mux = m[1]; cfg_wide = m[0]; cfg_wrl = s[0];
                bus_op(1, 16'h1234 + 16'(m*16 + s), 16'hA55A ^ 16'(m), 2'b11);
                bus_op(1, 16'h8001 + 16'(m), 16'h0FF0, 2'b01);
                bus_op(1, 16'h4002 + 16'(m), 16'hF00F, 2'b10);
                bus_op(0, 16'hC3A5 + 16'(m*2 + s), 16'h0000, 2'b11);
                bus_op(0, 16'h0F0F + 16'(m), 16'h0000, 2'b01);
            end
        end

        // R11: change configuration and fields inside a running cycle.
        cfg_mux = 1; cfg_wide = 1; cfg_wrl = 0;
        @(posedge clk); #1;
        req = 1; req_we = 1; req_addr = 16'hBEEF; req_wdata = 16'h1357; req_be = 2'b11;
        @(posedge clk); #1;
        cfg_mux = 0; cfg_wide = 0; cfg_wrl = 1;
        req_addr = 16'h0000; req_wdata = 16'hFFFF; req_we = 0;
        @(negedge clk);
        chk("R11", "ale after cfg change", ale, 1);
        chk("R11", "address after change", p0_out, 16'hBEEF);
        @(negedge clk);
        chk("R11", "write data after change", p0_out, 16'h1357);
        chk("R11", "p1 quiet after change", p1_oe, 0);
        chk("R11", "wr_n after change", wr_n, 0);
        do @(negedge clk); while (!ack);
        @(posedge clk); #1 req = 0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        compare_on = 0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule